// File: doc/BRIEF.md
# Seconds Counter with Alarm

A register-mapped real-time seconds counter for a simple 32-bit peripheral bus. A prescaler divides the system clock by `CLK_HZ` to make a one-cycle enable once per second. Each enable advances a 32-bit seconds count that wraps modulo 2^32. Software can write a new count through a load register. It can also program a 32-bit alarm value. When the count becomes equal to the alarm value, a raw alarm flag is set. A one-bit enable gates that flag onto a level-sensitive interrupt line.

Equality is tested after every event that can change either side: a tick, a load write or an alarm write. So a write that makes the two values equal raises the flag at once, without waiting for the next tick. Any write to the acknowledge register drops the flag, unless a new equality occurs in the same cycle. The control word always reads 1, because the counter cannot be stopped. An eight-word identification block sits at the top of the 4 KiB window.

Top module: `sec_alarm_rtc`

## Requirements
- R1: After reset the count, alarm value, load value, interrupt enable and raw flag are all zero, and `irq` is low.
- R2: The count at offset 0x000 advances by exactly 1 every `CLK_HZ` clock cycles. Writes to offsets 0x000, 0x014 and 0x018 change nothing.
- R3: A write to offset 0x008 makes the count equal the written value on the next cycle, and offset 0x008 reads back the last value written there.
- R4: Offset 0x004 stores a full 32-bit alarm value. When a tick makes the count equal to it, bit 0 of offset 0x014 (the raw flag) becomes 1 in the same cycle as the count changes.
- R5: A write to 0x004 or 0x008 that leaves the count equal to the alarm value sets the raw flag on the next cycle.
- R6: The count wraps from 0xFFFFFFFF to 0. An alarm value below the current count fires once the count wraps round to it.
- R7: Offset 0x010 keeps only bit 0 as the interrupt enable, and bits 31:1 read as 0. Offset 0x018 reads raw flag AND enable in bit 0, and `irq` equals that same value.
- R8: Any write to offset 0x01C clears the raw flag, whatever data is written. If an alarm equality occurs in that same cycle, the flag stays set instead. With no write to 0x01C, the flag stays set.
- R9: Offset 0x00C always reads 1, and writes to it are ignored.
- R10: The word offsets 0xFE0 to 0xFFC read, in order, 0x31, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1. Reads of 0x01C, of unmapped offsets and of addresses that are not word-aligned return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte offset within the 4 KiB window |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level interrupt: raw flag AND enable |

## Verification
The assertions assume that `bus_wr` is a clean one-cycle strobe, and that the address and data are stable whenever it is high. They also assume that the bus never writes two registers in one cycle, so a load write and an alarm write cannot coincide. The bench drives every input on the falling clock edge, holds each write for exactly one rising edge, and times writes against observed ticks. A clear can therefore be placed deliberately on a tick cycle, and load or alarm writes can be kept away from ticks when exact values are checked.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int DW = 32;
    localparam int AW = 12;

    localparam logic [AW-1:0] OFS_COUNT = 12'h000;
    localparam logic [AW-1:0] OFS_ALARM = 12'h004;
    localparam logic [AW-1:0] OFS_LOAD  = 12'h008;
    localparam logic [AW-1:0] OFS_CTRL  = 12'h00C;
    localparam logic [AW-1:0] OFS_EN    = 12'h010;
    localparam logic [AW-1:0] OFS_RAW   = 12'h014;
    localparam logic [AW-1:0] OFS_MASKD = 12'h018;
    localparam logic [AW-1:0] OFS_ACK   = 12'h01C;

    typedef enum logic [3:0] {
        SEL_COUNT, SEL_ALARM, SEL_LOAD, SEL_CTRL, SEL_EN,
        SEL_RAW, SEL_MASKD, SEL_ACK, SEL_IDENT, SEL_NONE
    } reg_sel_e;

    typedef struct packed {
        logic load;
        logic alarm;
        logic ack;
        logic en;
    } wr_strobe_t;

    function automatic reg_sel_e decode(input logic [AW-1:0] a);
        if (a[1:0] != 2'b00)           return SEL_NONE;
        if (a[AW-1:5] == '1)           return SEL_IDENT;
        case (a)
            OFS_COUNT: return SEL_COUNT;
            OFS_ALARM: return SEL_ALARM;
            OFS_LOAD:  return SEL_LOAD;
            OFS_CTRL:  return SEL_CTRL;
            OFS_EN:    return SEL_EN;
            OFS_RAW:   return SEL_RAW;
            OFS_MASKD: return SEL_MASKD;
            OFS_ACK:   return SEL_ACK;
            default:   return SEL_NONE;
        endcase
    endfunction

    function automatic logic [7:0] ident_byte(input logic [2:0] idx);
        case (idx)
            3'd0: return 8'h31;
            3'd1: return 8'h10;
            3'd2: return 8'h14;
            3'd3: return 8'h00;
            3'd4: return 8'h0D;
            3'd5: return 8'hF0;
            3'd6: return 8'h05;
            default: return 8'hB1;
        endcase
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int CLK_HZ = 50_000_000
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int PW = (CLK_HZ > 1) ? $clog2(CLK_HZ) : 1;

    generate
        if (CLK_HZ <= 1) begin : g_every
            assign tick = 1'b1;
        end else begin : g_div
            logic [PW-1:0] div_q;
            always_ff @(posedge clk) begin
                if (rst || div_q == PW'(CLK_HZ - 1)) div_q <= '0;
                else                                 div_q <= div_q + 1'b1;
            end
            assign tick = (div_q == PW'(CLK_HZ - 1));

            AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick); // R2
        end
    endgenerate
endmodule

// File: rtl/rtc_alarm_core.sv
module rtc_alarm_core
    import rtc_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  wr_strobe_t    wr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] count_q,
    output logic [DW-1:0] alarm_q,
    output logic [DW-1:0] load_q,
    output logic          en_q,
    output logic          raw_q,
    output logic          irq
);
    logic [DW-1:0] count_d;
    logic [DW-1:0] alarm_d;
    logic          hit;

    always_comb begin
        count_d = count_q;
        if (wr.load)      count_d = wdata;
        else if (tick)    count_d = count_q + 1'b1;
        alarm_d = wr.alarm ? wdata : alarm_q;
        hit     = (tick || wr.load || wr.alarm) && (count_d == alarm_d);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            alarm_q <= '0;
            load_q  <= '0;
            en_q    <= 1'b0;
            raw_q   <= 1'b0;
        end else begin
            count_q <= count_d;
            alarm_q <= alarm_d;
            if (wr.load) load_q <= wdata;
            if (wr.en)   en_q   <= wdata[0];
            if (hit)         raw_q <= 1'b1;
            else if (wr.ack) raw_q <= 1'b0;
        end
    end

    assign irq = raw_q & en_q;

    AST_LOAD_APPLIES: assert property (@(posedge clk) disable iff (rst)
        wr.load |=> (count_q == $past(wdata))); // R3
    AST_WRITE_MATCH: assert property (@(posedge clk) disable iff (rst)
        (wr.load && !wr.alarm && wdata == alarm_q) |=> raw_q); // R5
    AST_COUNT_WRAP: assert property (@(posedge clk) disable iff (rst)
        (tick && !wr.load && count_q == '1) |=> (count_q == '0)); // R6
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (wr.ack && !tick && !wr.load && !wr.alarm) |=> !raw_q); // R8
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (raw_q && !wr.ack) |=> raw_q); // R8
endmodule

// File: rtl/rtc_read_mux.sv
module rtc_read_mux
    import rtc_pkg::*;
(
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] count_q,
    input  logic [DW-1:0] alarm_q,
    input  logic [DW-1:0] load_q,
    input  logic          en_q,
    input  logic          raw_q,
    output logic [DW-1:0] rdata
);
    always_comb begin
        rdata = '0;
        case (decode(addr))
            SEL_COUNT: rdata = count_q;
            SEL_ALARM: rdata = alarm_q;
            SEL_LOAD:  rdata = load_q;
            SEL_CTRL:  rdata = DW'(1);
            SEL_EN:    rdata = DW'(en_q);
            SEL_RAW:   rdata = DW'(raw_q);
            SEL_MASKD: rdata = DW'(raw_q & en_q);
            SEL_IDENT: rdata = DW'(ident_byte(addr[4:2]));
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/sec_alarm_rtc.sv
module sec_alarm_rtc
    import rtc_pkg::*;
#(
    parameter int CLK_HZ = 50_000_000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [11:0]   bus_addr,
    input  logic          bus_wr,
    input  logic [31:0]   bus_wdata,
    output logic [31:0]   bus_rdata,
    output logic          irq
);
    logic          tick;
    wr_strobe_t    wr;
    reg_sel_e      sel;
    logic [DW-1:0] count_q, alarm_q, load_q;
    logic          en_q, raw_q;

    assign sel      = decode(bus_addr);
    assign wr.load  = bus_wr && (sel == SEL_LOAD);
    assign wr.alarm = bus_wr && (sel == SEL_ALARM);
    assign wr.ack   = bus_wr && (sel == SEL_ACK);
    assign wr.en    = bus_wr && (sel == SEL_EN);

    rtc_prescaler #(.CLK_HZ(CLK_HZ)) u_presc (
        .clk(clk), .rst(rst), .tick(tick)
    );

    rtc_alarm_core u_core (
        .clk(clk), .rst(rst), .tick(tick), .wr(wr), .wdata(bus_wdata),
        .count_q(count_q), .alarm_q(alarm_q), .load_q(load_q),
        .en_q(en_q), .raw_q(raw_q), .irq(irq)
    );

    rtc_read_mux u_rmux (
        .addr(bus_addr), .count_q(count_q), .alarm_q(alarm_q),
        .load_q(load_q), .en_q(en_q), .raw_q(raw_q), .rdata(bus_rdata)
    );

    AST_EN_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == OFS_EN) |-> (bus_rdata[31:1] == '0)); // R7
    AST_CTRL_ONE: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == OFS_CTRL) |-> (bus_rdata == 32'd1)); // R9
endmodule

// File: tb/test_sec_alarm_rtc.sv
module test_sec_alarm_rtc;
    localparam int HZ = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int failures = 0;

    sec_alarm_rtc #(.CLK_HZ(HZ)) i_sec_alarm_rtc (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
        #1;
    endtask

    task automatic wait_tick(output int cyc);
        logic [31:0] c0, c1;
        cyc = 0;
        rd(12'h000, c0);
        c1 = c0;
        while (c1 == c0 && cyc < 40) begin
            @(negedge clk); #1;
            rd(12'h000, c1);
            cyc++;
        end
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(12'h000, d); check("R1 count", d, 0);
        rd(12'h004, d); check("R1 alarm", d, 0);
        rd(12'h008, d); check("R1 load", d, 0);
        rd(12'h010, d); check("R1 enable", d, 0);
        rd(12'h014, d); check("R1 raw", d, 0);
        check("R1 irq", {31'b0, irq}, 0);
    endtask

    task automatic t_tick_rate;
        int cyc;
        logic [31:0] a, b;
        wait_tick(cyc);
        rd(12'h000, a);
        wait_tick(cyc);
        rd(12'h000, b);
        check("R2 period", cyc, HZ);
        check("R2 increment", b, a + 1);
        wait_tick(cyc);
        rd(12'h000, a);
        wr(12'h000, 32'hDEAD0000);
        wr(12'h014, 32'h1);
        wr(12'h018, 32'h1);
        rd(12'h000, b); check("R2 count write ignored", b, a);
        rd(12'h014, b); check("R2 raw write ignored", b, 0);
    endtask

    task automatic t_load;
        int cyc;
        logic [31:0] d;
        wait_tick(cyc);
        wr(12'h008, 32'h1234_5678);
        rd(12'h000, d); check("R3 count loaded", d, 32'h1234_5678);
        rd(12'h008, d); check("R3 load readback", d, 32'h1234_5678);
    endtask

    task automatic t_tick_match;
        int cyc;
        logic [31:0] d;
        wait_tick(cyc);
        wr(12'h008, 32'd10);
        wr(12'h004, 32'd12);
        wr(12'h01C, 32'h0);
        rd(12'h004, d); check("R4 alarm readback", d, 12);
        wait_tick(cyc);
        rd(12'h014, d); check("R4 no flag at 11", d, 0);
        wait_tick(cyc);
        rd(12'h000, d); check("R4 count 12", d, 12);
        rd(12'h014, d); check("R4 flag at 12", d, 1);
        rd(12'h018, d); check("R7 masked while disabled", d, 0);
        check("R7 irq while disabled", {31'b0, irq}, 0);
        wr(12'h010, 32'hFFFF_FFFF);
        rd(12'h010, d); check("R7 enable one bit", d, 1);
        rd(12'h018, d); check("R7 masked status", d, 1);
        check("R7 irq high", {31'b0, irq}, 1);
        wr(12'h010, 32'hFFFF_FFFE);
        check("R7 irq follows enable", {31'b0, irq}, 0);
        wr(12'h010, 32'h1);
        wr(12'h01C, 32'h0);
        rd(12'h014, d); check("R8 clear any data", d, 0);
        check("R8 irq dropped", {31'b0, irq}, 0);
    endtask

    task automatic t_write_match;
        int cyc;
        logic [31:0] d;
        wait_tick(cyc);
        wr(12'h004, 32'h77);
        rd(12'h014, d); check("R5 no flag when unequal", d, 0);
        wr(12'h008, 32'h77);
        rd(12'h014, d); check("R5 load equal sets flag", d, 1);
        wait_tick(cyc);
        wr(12'h01C, 32'h0);
        rd(12'h000, d);
        wr(12'h004, d);
        rd(12'h014, d); check("R5 alarm write equal sets flag", d, 1);
    endtask

    task automatic t_wrap;
        int cyc;
        logic [31:0] d;
        wait_tick(cyc);
        wr(12'h008, 32'hFFFF_FFFF);
        wr(12'h004, 32'd1);
        wr(12'h01C, 32'h0);
        wait_tick(cyc);
        rd(12'h000, d); check("R6 wrap to zero", d, 0);
        rd(12'h014, d); check("R6 no flag at zero", d, 0);
        wait_tick(cyc);
        rd(12'h014, d); check("R6 flag after wrap", d, 1);
    endtask

    task automatic t_clear_vs_hit;
        int cyc;
        logic [31:0] cur, d;
        wait_tick(cyc);
        rd(12'h000, cur);
        wr(12'h004, cur + 1);
        wr(12'h01C, 32'h0);
        rd(12'h014, d); check("R8 cleared before tick", d, 0);
        @(negedge clk); #1;
        wr(12'h01C, 32'h0);
        rd(12'h000, d); check("R8 tick landed with clear", d, cur + 1);
        rd(12'h014, d); check("R8 hit beats clear", d, 1);
        @(negedge clk); #1;
        rd(12'h014, d); check("R8 flag holds", d, 1);
    endtask

    task automatic t_ctrl_ident;
        logic [31:0] d;
        logic [7:0] exp_id [8];
        exp_id = '{8'h31, 8'h10, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
        wr(12'h00C, 32'h0);
        rd(12'h00C, d); check("R9 control reads one", d, 1);
        for (int i = 0; i < 8; i++) begin
            rd(12'hFE0 + 12'(i * 4), d);
            check("R10 ident", d, {24'b0, exp_id[i]});
        end
        rd(12'h01C, d); check("R10 ack reads zero", d, 0);
        rd(12'h020, d); check("R10 unmapped zero", d, 0);
        rd(12'h002, d); check("R10 unaligned zero", d, 0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset();
        t_tick_rate();
        t_load();
        t_tick_match();
        t_write_match();
        t_wrap();
        t_clear_vs_hit();
        t_ctrl_ident();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule